// File: doc/BRIEF.md
# Paged Lookup-Table Address Translator

This block remaps request addresses that fall inside one programmable memory window into a second address domain. The window is always cut into 64 pages of equal size. Every page has its own table entry holding a translated page base, a valid bit and a prefetchable attribute, so the 64 pages can be scattered independently across the target space.

Software programs the window base, a page-size code and the 64 entries through a small register port: a four-slot select with write data and combinational read-back. Table entries are reached indirectly, by first writing an entry pointer and then reading or writing the entry data slot. On the lookup side, a request address qualified by a strobe produces a registered result one clock later. That result carries a hit flag, the translated address, the page's prefetchable attribute, and a miss flag for addresses that land in the window on a page whose entry is invalid.

Top module: `lpt_xlate_top`

## Requirements
- R1: After a synchronous active-low reset, xl_done, xl_hit, xl_miss, xl_pref and xl_addr are 0. The window base, size code and entry pointer read back as 0, and every table entry reads back as 0, which means invalid.
- R2: The result for a request presented with req_vld high at a clock edge appears on the outputs after that edge, with xl_done high for exactly that one cycle. In any cycle with no request, xl_done, xl_hit and xl_miss are 0.
- R3: A page size code c selects a page of 2^(8+c) bytes and a window of 64 such pages. Codes above 17 act as 17, which gives 32 MB pages in a 2 GB window. The read-back of the size slot returns the raw code as written.
- R4: An address is inside the window when it matches the window base on all bits at and above position 8+c+6. The base bits below that position are ignored, so the window is always aligned to its own size.
- R5: An address outside the window gives xl_hit=0 and xl_miss=0, with xl_addr=0 and xl_pref=0.
- R6: For an address inside the window, the page index is bits [8+c+5 : 8+c] of the address. On a valid entry, xl_hit=1 and xl_addr is the entry's page base above bit 8+c with the request's address bits below 8+c passed through unchanged.
- R7: An address inside the window whose entry has valid=0 gives xl_miss=1, xl_hit=0, xl_addr=0 and xl_pref=0.
- R8: On a hit, xl_pref equals the prefetchable bit of the selected entry.
- R9: Register map on cfg_sel: 0 is the window base (32 bits), 1 is the size code (bits [4:0]), 2 is the entry pointer (bits [5:0]), and 3 is the entry data for the entry at the pointer. The entry data format is bits [31:8] for the translated page base, bit 1 for prefetchable and bit 0 for valid. Bits [7:2] are written as don't-care and read as 0. A write happens when cfg_wr is high at a clock edge. cfg_rdata always shows the slot chosen by cfg_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Address to translate |
| cfg_wr | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register slot select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected slot |
| xl_done | output | 1 | Result valid, one cycle after the strobe |
| xl_hit | output | 1 | Address translated through a valid entry |
| xl_miss | output | 1 | Address in window, entry invalid |
| xl_pref | output | 1 | Prefetchable attribute of the hit page |
| xl_addr | output | 32 | Translated address, 0 when not a hit |

## Verification
A stale or misdecoded size code moves the window boundary and the split between page index and offset bits. That shows up on the very next lookup as a hit on the wrong entry, passed-through offset bits that are too few or too many, or a hit that should have been out of window. A wrong entry-pointer or entry-storage state is visible at once on the entry read-back slot. It also shows one cycle after any lookup of that page, as the wrong translated base, valid or prefetchable value. Lookups near the edges of the window and at both extremes of the size code expose shifting errors that mid-range cases hide.

// File: rtl/xlt_pkg.sv
// Package: shared constants, the register slot encoding and the table entry type.
// Assumes the address and register data widths are equal.
package xlt_pkg;
    parameter int ADDR_W    = 32;
    parameter int IDX_W     = 6;
    parameter int MIN_SHIFT = 8;
    parameter int MAX_CODE  = 17;
    parameter int CODE_W    = 5;
    parameter int SEL_W     = 2;

    localparam int NUM_PAGES = 1 << IDX_W;
    localparam int PB_W      = ADDR_W - MIN_SHIFT;
    localparam int SHIFT_W   = $clog2(ADDR_W + 1);

    typedef enum logic [SEL_W-1:0] {
        SLOT_BASE  = 2'd0,
        SLOT_SIZE  = 2'd1,
        SLOT_PTR   = 2'd2,
        SLOT_ENTRY = 2'd3
    } cfg_slot_e;

    typedef struct packed {
        logic [PB_W-1:0] page_base;
        logic            pref;
        logic            vld;
    } xlt_entry_t;
endpackage

// File: rtl/xlt_cfg_regs.sv
// Configuration registers: window base, page size code and entry pointer.
// It produces the table write strobe and the read-back mux.
// Assumes the table read at the pointer is combinational.
module xlt_cfg_regs
    import xlt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  xlt_entry_t           ptr_entry,
    output logic [ADDR_W-1:0]    win_base,
    output logic [CODE_W-1:0]    size_code,
    output logic [IDX_W-1:0]     ent_ptr,
    output logic                 tbl_we,
    output xlt_entry_t           tbl_wdata,
    output logic [ADDR_W-1:0]    cfg_rdata
);
    logic unused_wbits;

    // Register writes to the base, size and pointer slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_base  <= '0;
            size_code <= '0;
            ent_ptr   <= '0;
        end else if (cfg_wr) begin
            case (cfg_slot_e'(cfg_sel))
                SLOT_BASE: win_base  <= cfg_wdata;
                SLOT_SIZE: size_code <= cfg_wdata[CODE_W-1:0];
                SLOT_PTR:  ent_ptr   <= cfg_wdata[IDX_W-1:0];
                default:   ;
            endcase
        end
    end

    // Unpack entry-slot writes into the entry format.
    always_comb begin
        tbl_we              = cfg_wr && (cfg_slot_e'(cfg_sel) == SLOT_ENTRY);
        tbl_wdata.page_base = cfg_wdata[ADDR_W-1:MIN_SHIFT];
        tbl_wdata.pref      = cfg_wdata[1];
        tbl_wdata.vld       = cfg_wdata[0];
    end

    assign unused_wbits = ^cfg_wdata[MIN_SHIFT-1:2];

    // Read-back mux over the four slots.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_slot_e'(cfg_sel))
            SLOT_BASE:  cfg_rdata = win_base;
            SLOT_SIZE:  cfg_rdata[CODE_W-1:0] = size_code;
            SLOT_PTR:   cfg_rdata[IDX_W-1:0]  = ent_ptr;
            SLOT_ENTRY: cfg_rdata = {ptr_entry.page_base, {(MIN_SHIFT-2){1'b0}},
                                     ptr_entry.pref, ptr_entry.vld};
            default:    cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlt_page_table.sv
// Page table: NUM_PAGES entries in flops, one write port and two read ports.
// One read port serves lookups, the other serves configuration read-back.
// Assumes a lookup and a write to the same entry in one cycle see the old entry.
module xlt_page_table
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  xlt_entry_t        wdata,
    input  logic [IDX_W-1:0]  lk_idx,
    output xlt_entry_t        lk_entry,
    output xlt_entry_t        ptr_entry
);
    xlt_entry_t ent_q [NUM_PAGES];

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_entry
        // Entry storage; cleared to invalid on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[g] <= '0;
            else if (we && (wr_idx == IDX_W'(g)))
                ent_q[g] <= wdata;
        end
    end

    // Combinational read ports.
    always_comb begin
        lk_entry  = ent_q[lk_idx];
        ptr_entry = ent_q[wr_idx];
    end
endmodule

// File: rtl/xlt_window_decode.sv
// Window decode: it saturates the size code, tests window membership, and
// extracts the page index and the offset mask.
// Assumes the window base is aligned to the window size, and ignores its low bits.
module xlt_window_decode
    import xlt_pkg::*;
(
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] win_base,
    input  logic [CODE_W-1:0] size_code,
    output logic              in_win,
    output logic [IDX_W-1:0]  page_idx,
    output logic [ADDR_W-1:0] off_mask
);
    logic [CODE_W-1:0]  code_sat;
    logic [SHIFT_W-1:0] pg_shift;
    logic [SHIFT_W-1:0] win_shift;
    logic [ADDR_W-1:0]  diff;
    logic [ADDR_W-1:0]  ones;

    // Clamp the code and derive the page and window shift amounts.
    always_comb begin
        code_sat  = (size_code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : size_code;
        pg_shift  = SHIFT_W'(MIN_SHIFT) + SHIFT_W'(code_sat);
        win_shift = pg_shift + SHIFT_W'(IDX_W);
    end

    // Membership test, page index and offset mask.
    always_comb begin
        ones     = '1;
        diff     = req_addr ^ win_base;
        in_win   = ((diff >> win_shift) == '0);
        page_idx = IDX_W'(req_addr >> pg_shift);
        off_mask = ~(ones << pg_shift);
    end
endmodule

// File: rtl/lpt_xlate_top.sv
// Top: paged lookup-table address translator with a registered result.
// Assumes the requester accepts a result one cycle after each strobe.
module lpt_xlate_top
    import xlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [31:0]       req_addr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              xl_done,
    output logic              xl_hit,
    output logic              xl_miss,
    output logic              xl_pref,
    output logic [31:0]       xl_addr
);
    logic [ADDR_W-1:0] win_base;
    logic [CODE_W-1:0] size_code;
    logic [IDX_W-1:0]  ent_ptr;
    logic              tbl_we;
    xlt_entry_t        tbl_wdata;
    xlt_entry_t        lk_entry;
    xlt_entry_t        ptr_entry;
    logic              in_win;
    logic [IDX_W-1:0]  page_idx;
    logic [ADDR_W-1:0] off_mask;
    logic [ADDR_W-1:0] xl_next;

    xlt_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ptr_entry (ptr_entry),
        .win_base  (win_base),
        .size_code (size_code),
        .ent_ptr   (ent_ptr),
        .tbl_we    (tbl_we),
        .tbl_wdata (tbl_wdata),
        .cfg_rdata (cfg_rdata)
    );

    xlt_page_table u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tbl_we),
        .wr_idx    (ent_ptr),
        .wdata     (tbl_wdata),
        .lk_idx    (page_idx),
        .lk_entry  (lk_entry),
        .ptr_entry (ptr_entry)
    );

    xlt_window_decode u_dec (
        .req_addr  (req_addr),
        .win_base  (win_base),
        .size_code (size_code),
        .in_win    (in_win),
        .page_idx  (page_idx),
        .off_mask  (off_mask)
    );

    // Merge the entry page base with the passed-through offset bits.
    always_comb begin
        xl_next = ({lk_entry.page_base, {MIN_SHIFT{1'b0}}} & ~off_mask)
                | (req_addr & off_mask);
    end

    // Result register: outputs stay quiet unless a strobe arrived last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_done <= 1'b0;
            xl_hit  <= 1'b0;
            xl_miss <= 1'b0;
            xl_pref <= 1'b0;
            xl_addr <= '0;
        end else begin
            xl_done <= req_vld;
            xl_hit  <= req_vld && in_win && lk_entry.vld;
            xl_miss <= req_vld && in_win && !lk_entry.vld;
            xl_pref <= req_vld && in_win && lk_entry.vld && lk_entry.pref;
            xl_addr <= (req_vld && in_win && lk_entry.vld) ? xl_next : '0;
        end
    end
endmodule

// File: rtl/lpt_xlate_chk.sv
// Checker: temporal properties on the translator ports, bound to the top.
module lpt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic [31:0] req_addr,
    input logic        xl_done,
    input logic        xl_hit,
    input logic        xl_miss,
    input logic        xl_pref,
    input logic [31:0] xl_addr
);
    // R2
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> xl_done);
    // R2
    quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !(xl_done || xl_hit || xl_miss));
    // R7
    hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_hit && xl_miss));
    // R5
    idle_result_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_hit |-> (xl_addr == 32'd0 && !xl_pref));
    // R6
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (!xl_hit || xl_addr[7:0] == $past(req_addr[7:0])));
endmodule

bind lpt_xlate_top lpt_xlate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_addr (req_addr),
    .xl_done  (xl_done),
    .xl_hit   (xl_hit),
    .xl_miss  (xl_miss),
    .xl_pref  (xl_pref),
    .xl_addr  (xl_addr)
);

// File: tb/lpt_xlate_top_tb.sv
module lpt_xlate_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {addr, hit, miss, pref, xaddr}
    localparam logic [66:0] VECS [NVEC] = '{
        {32'h4000_0123, 1'b1, 1'b0, 1'b0, 32'h8000_0123},
        {32'h4000_1FFF, 1'b1, 1'b0, 1'b1, 32'h1234_5FFF},
        {32'h4003_F004, 1'b1, 1'b0, 1'b0, 32'hABCD_E004},
        {32'h4000_5010, 1'b0, 1'b1, 1'b0, 32'h0000_0000},
        {32'h4004_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h3FFF_FFFF, 1'b0, 1'b0, 1'b0, 32'h0000_0000},
        {32'h4000_2000, 1'b0, 1'b1, 1'b0, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        xl_done, xl_hit, xl_miss, xl_pref;
    logic [31:0] xl_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpt_xlate_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xl_done(xl_done), .xl_hit(xl_hit),
        .xl_miss(xl_miss), .xl_pref(xl_pref), .xl_addr(xl_addr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #(CLK_PERIOD/4);
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic set_entry(input int idx, input logic [31:0] d);
        reg_wr(2'd2, 32'(idx));
        reg_wr(2'd3, d);
    endtask

    task automatic lookup(input logic [31:0] a, input logic eh, input logic em,
                          input logic ep, input logic [31:0] ex, input string tag);
        @(negedge clk);
        req_vld = 1'b1; req_addr = a;
        @(negedge clk);
        req_vld = 1'b0;
        #(CLK_PERIOD/4);
        chk({tag, " done"}, 32'(xl_done), 32'd1);
        chk({tag, " flags"}, {29'd0, xl_hit, xl_miss, xl_pref}, {29'd0, eh, em, ep});
        chk({tag, " addr"}, xl_addr, ex);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        #(CLK_PERIOD/4);
        // R1 reset outputs and registers
        chk("R1 outputs", {27'd0, xl_done, xl_hit, xl_miss, xl_pref, 1'b0}, 32'd0);
        chk("R1 xl_addr", xl_addr, 32'd0);
        reg_rd(2'd0, 32'd0, "R1 base");
        reg_rd(2'd1, 32'd0, "R1 size");
        reg_rd(2'd2, 32'd0, "R1 ptr");
        reg_rd(2'd3, 32'd0, "R1 entry0");
        // R1 entries invalid after reset: window at 0, 256 B pages
        lookup(32'h0000_0010, 1'b0, 1'b1, 1'b0, 32'd0, "R1 invalid after reset");

        // Setup: 4 KB pages (code 4), window at 0x4000_0000
        reg_wr(2'd0, 32'h4000_0000);
        reg_wr(2'd1, 32'd4);
        set_entry(0,  32'h8000_0001);
        set_entry(1,  32'h1234_50FF);   // don't-care bits [7:2] set; pref and valid
        set_entry(63, 32'hABCD_E001);
        set_entry(5,  32'h5555_5000);
        // R9 readback of entry format
        reg_wr(2'd2, 32'd1);
        reg_rd(2'd2, 32'd1, "R9 ptr");
        reg_rd(2'd3, 32'h1234_5003, "R9 entry1");
        reg_rd(2'd0, 32'h4000_0000, "R9 base");

        // R3 R5 R6 R7 R8 vector walk
        for (int i = 0; i < NVEC; i++) begin
            lookup(VECS[i][66:35], VECS[i][34], VECS[i][33], VECS[i][32],
                   VECS[i][31:0], $sformatf("R6 R7 R8 vec%0d", i));
        end

        // R2 no strobe: flags return to zero
        @(negedge clk);
        chk("R2 quiet", {29'd0, xl_done, xl_hit, xl_miss}, 32'd0);

        // R4 base low bits ignored
        reg_wr(2'd0, 32'h4000_0ABC);
        lookup(32'h4000_0123, 1'b1, 1'b0, 1'b0, 32'h8000_0123, "R4 base low bits");

        // R3 smallest pages: code 0, 256 B pages
        reg_wr(2'd0, 32'h4000_0000);
        reg_wr(2'd1, 32'd0);
        lookup(32'h4000_0155, 1'b1, 1'b0, 1'b1, 32'h1234_5055, "R3 code0");
        lookup(32'h4000_4000, 1'b0, 1'b0, 1'b0, 32'd0, "R5 code0 edge");

        // R3 saturation: code 20 acts as 17 (32 MB pages, 2 GB window)
        reg_wr(2'd1, 32'd20);
        reg_rd(2'd1, 32'd20, "R3 raw code");
        lookup(32'h0200_0010, 1'b1, 1'b0, 1'b1, 32'h1200_0010, "R3 R4 code sat");
        lookup(32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h8000_0000, "R3 code sat page0");
        lookup(32'h8000_0000, 1'b0, 1'b0, 1'b0, 32'd0, "R5 code sat outside");

        // R1 second reset clears table
        do_reset();
        reg_wr(2'd2, 32'd1);
        reg_rd(2'd3, 32'd0, "R1 entry1 cleared");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule